// File: doc/BRIEF.md
# Fused Multiply-Add Special-Value Override Stage

This stage sits at the end of a binary64 fused multiply-add unit that computes `addend + mul_a × mul_b`, or the subtract form of the same operation. The arithmetic datapath delivers a provisional result and provisional exception flags. This stage decides whether a NaN operand, or an infinity multiplied by a zero, replaces them.

Each of the three operands is classified as NaN, signalling NaN, infinity or zero. When at least one operand is a NaN, the returned value is that operand in quiet form. The addend is chosen before the second multiplicand, and the second multiplicand before the first. This is not the operands' argument order. The invalid flag is raised for any signalling operand, and for infinity times zero, whether or not the addend is a NaN.

The stage is registered. An accepted input appears at the outputs one clock later.

Top module: `fma_nan_override`

## Requirements
- R1: When the addend is a NaN, the result is the addend in quiet form, whatever the multiplicands are.
- R2: When the addend is not a NaN and both multiplicands are NaNs, the result is the quieted `mul_b`. A single NaN multiplicand is returned quieted.
- R3: A returned NaN has mantissa bit 51 (the quiet bit) set. Its sign, its exponent and its other mantissa bits are equal to those of the chosen operand. An operand is a NaN when bits 62:52 are all ones and bits 51:0 are not zero. It is signalling when bit 51 is clear.
- R4: The invalid flag is raised whenever any operand is a signalling NaN, including when another NaN is the one returned.
- R5: When one multiplicand is infinity and the other is zero (either sign), neither is a NaN, and the addend is not a NaN, the result is 0x7FF8000000000000 and invalid is raised.
- R6: When one multiplicand is infinity, the other is zero, and the addend is a NaN, the result is the quieted addend and invalid is raised. This holds whether the addend is quiet or signalling.
- R7: Quiet NaN operands raise no flag when no operand is signalling and there is no infinity-times-zero case.
- R8: `sub_sel` has no effect on which NaN is returned or on the flags of an overridden result.
- R9: An overridden result has the overflow, underflow and inexact flags at zero. Flags are encoded as bit 3 invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact.
- R10: When no operand is a NaN and there is no infinity-times-zero case, `dp_result` and `dp_flags` are passed through unchanged.
- R11: `out_valid` follows `in_valid` one cycle later, and the result and flags appear in that same cycle. While `in_valid` is low, the outputs hold their values.
- R12: During reset, `out_valid`, `out_result` and `out_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and provisional result are valid |
| addend | input | 64 | Addend operand |
| mul_a | input | 64 | First multiplicand |
| mul_b | input | 64 | Second multiplicand |
| sub_sel | input | 1 | Subtract form of the operation |
| dp_result | input | 64 | Provisional result from the arithmetic path |
| dp_flags | input | 4 | Provisional flags {invalid, overflow, underflow, inexact} |
| out_valid | output | 1 | Output is valid |
| out_result | output | 64 | Final result |
| out_flags | output | 4 | Final flags {invalid, overflow, underflow, inexact} |

## Verification
Each test uses distinct payloads in the three operands, so the returned NaN shows which operand won. Four patterns exercise the priority order:
- a lone NaN in each operand position;
- every pair of NaN operands;
- all three operands NaN;
- a signalling NaN beside a quiet NaN that has higher priority, which separates the choice of result from the invalid decision.

Infinity times zero is tried three ways: with an ordinary addend, with a quiet NaN addend, and with a signalling NaN addend. This shows that the default NaN applies only when the addend is not a NaN, and that invalid is still raised when the addend is a NaN. Further tests check that ordinary and infinite operands pass the provisional values through, and that the subtract select does not change a NaN outcome.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

   typedef struct packed {
      logic invalid;
      logic overflow;
      logic underflow;
      logic inexact;
   } fma_flags_t;

   localparam int unsigned OP_COUNT = 3;
   // operand slots: higher index wins the NaN selection
   localparam int unsigned SLOT_MUL_A  = 0;
   localparam int unsigned SLOT_MUL_B  = 1;
   localparam int unsigned SLOT_ADDEND = 2;

endpackage

// File: rtl/fma_nan_classify.sv
module fma_nan_classify #(
   parameter int unsigned EXP_W = 11,
   parameter int unsigned MAN_W = 52,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] op,
   output logic         is_nan,
   output logic         is_snan,
   output logic         is_inf,
   output logic         is_zero
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max;
   logic             man_any;

   assign exp_f   = op[W-2:MAN_W];
   assign man_f   = op[MAN_W-1:0];
   assign exp_max = &exp_f;
   assign man_any = |man_f;

   assign is_nan  = exp_max & man_any;
   assign is_snan = exp_max & man_any & ~man_f[MAN_W-1];
   assign is_inf  = exp_max & ~man_any;
   assign is_zero = ~(|op[W-2:0]);

endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
   import fma_nan_pkg::*;
#(
   parameter int unsigned EXP_W = 11,
   parameter int unsigned MAN_W = 52,
   localparam int unsigned W = 1 + EXP_W + MAN_W
) (
   input  logic [OP_COUNT-1:0][W-1:0] ops,
   input  logic [OP_COUNT-1:0]        nan_v,
   input  logic [OP_COUNT-1:0]        snan_v,
   input  logic                       inf_zero,
   input  logic [W-1:0]               dp_result,
   input  fma_flags_t                 dp_flags,
   output logic                       override,
   output logic [W-1:0]               res,
   output fma_flags_t                 flags
);

   localparam logic [W-1:0] QUIET_MASK = W'(1) << (MAN_W - 1);
   localparam logic [W-1:0] EXP_MASK   = ((W'(1) << EXP_W) - W'(1)) << MAN_W;
   localparam logic [W-1:0] DEF_NAN    = EXP_MASK | QUIET_MASK;

   logic         any_nan;
   logic [W-1:0] nan_pick;

   always_comb begin
      any_nan  = 1'b0;
      nan_pick = '0;
      for (int i = 0; i < OP_COUNT; i++) begin
         if (nan_v[i]) begin
            any_nan  = 1'b1;
            nan_pick = ops[i] | QUIET_MASK;
         end
      end
   end

   always_comb begin
      override = any_nan | inf_zero;
      if (any_nan) begin
         res = nan_pick;
      end else if (inf_zero) begin
         res = DEF_NAN;
      end else begin
         res = dp_result;
      end
      if (override) begin
         flags           = '0;
         flags.invalid   = (|snan_v) | inf_zero;
      end else begin
         flags = dp_flags;
      end
   end

   // an overridden value must itself be a NaN (R3)
   always_comb begin
      if (override) begin
         assert_override_is_nan_R3: assert ((res & EXP_MASK) == EXP_MASK && res[MAN_W-1]);
      end
   end

endmodule

// File: rtl/fma_nan_override.sv
module fma_nan_override
   import fma_nan_pkg::*;
#(
   parameter int unsigned EXP_W = 11,
   parameter int unsigned MAN_W = 52,
   localparam int unsigned W = 1 + EXP_W + MAN_W,
   localparam int unsigned FLAG_W = $bits(fma_flags_t)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [W-1:0]      addend,
   input  logic [W-1:0]      mul_a,
   input  logic [W-1:0]      mul_b,
   input  logic              sub_sel,
   input  logic [W-1:0]      dp_result,
   input  logic [FLAG_W-1:0] dp_flags,
   output logic              out_valid,
   output logic [W-1:0]      out_result,
   output logic [FLAG_W-1:0] out_flags
);

   localparam logic [W-1:0] QUIET_MASK = W'(1) << (MAN_W - 1);

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("EXP_W must be at least 2");
      end
      if (MAN_W < 2) begin : g_bad_man
         $error("MAN_W must be at least 2");
      end
   endgenerate

   logic [OP_COUNT-1:0][W-1:0] ops;
   logic [OP_COUNT-1:0]        nan_v, snan_v, inf_v, zero_v;
   logic                       inf_zero;
   logic                       override;
   logic [W-1:0]               pick_res;
   fma_flags_t                 pick_flags;

   assign ops[SLOT_MUL_A]  = mul_a;
   assign ops[SLOT_MUL_B]  = mul_b;
   assign ops[SLOT_ADDEND] = addend;

   generate
      for (genvar g = 0; g < OP_COUNT; g++) begin : g_cls
         fma_nan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .op      (ops[g]),
            .is_nan  (nan_v[g]),
            .is_snan (snan_v[g]),
            .is_inf  (inf_v[g]),
            .is_zero (zero_v[g])
         );
      end
   endgenerate

   assign inf_zero = (inf_v[SLOT_MUL_A] & zero_v[SLOT_MUL_B]) |
                     (zero_v[SLOT_MUL_A] & inf_v[SLOT_MUL_B]);

   fma_nan_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pick (
      .ops       (ops),
      .nan_v     (nan_v),
      .snan_v    (snan_v),
      .inf_zero  (inf_zero),
      .dp_result (dp_result),
      .dp_flags  (fma_flags_t'(dp_flags)),
      .override  (override),
      .res       (pick_res),
      .flags     (pick_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_flags  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= pick_res;
            out_flags  <= pick_flags;
         end
      end
   end

   assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(in_valid));

   assert_addend_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && nan_v[SLOT_ADDEND] |=> out_result == ($past(addend) | QUIET_MASK));

   assert_snan_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (|snan_v) |=> out_flags[3]);

   assert_nan_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (|nan_v) |=> out_flags[2:0] == '0);

   assert_sub_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && sub_sel && nan_v[SLOT_MUL_B] && !nan_v[SLOT_ADDEND]
      |=> out_result == ($past(mul_b) | QUIET_MASK));

   assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !(|nan_v) && !inf_zero
      |=> out_result == $past(dp_result) && out_flags == $past(dp_flags));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result) && $stable(out_flags));

   assert_override_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
      override |-> (|pick_flags) == pick_flags.invalid);

endmodule

// File: tb/fma_nan_override_bench.sv
`timescale 1ns/1ps
module fma_nan_override_bench;

   localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
   localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
   localparam logic [63:0] ZERO = 64'h0;
   localparam logic [63:0] NZRO = 64'h8000_0000_0000_0000;
   localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] SPILL = 64'h1234_5678_9ABC_DEF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] addend = '0, mul_a = '0, mul_b = '0, dp_result = '0;
   logic        sub_sel = 1'b0;
   logic [3:0]  dp_flags = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic [3:0]  out_flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fma_nan_override u_fma_nan_override (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .addend(addend), .mul_a(mul_a), .mul_b(mul_b), .sub_sel(sub_sel),
      .dp_result(dp_result), .dp_flags(dp_flags),
      .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags)
   );

   function automatic logic [63:0] qn(input logic [51:0] p);
      return 64'h7FF8_0000_0000_0000 | 64'(p);
   endfunction
   function automatic logic [63:0] sn(input logic [50:0] p);
      return 64'h7FF0_0000_0000_0000 | 64'(p);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one accepted operation; outputs sampled a full cycle later, away from the edge
   task automatic run(input logic [63:0] a, input logic [63:0] ma, input logic [63:0] mb,
                      input logic sub, input logic [63:0] dpr, input logic [3:0] dpf,
                      input string req, input logic [63:0] exp_r, input logic [3:0] exp_f);
      @(negedge clk);
      in_valid = 1'b1; addend = a; mul_a = ma; mul_b = mb; sub_sel = sub;
      dp_result = dpr; dp_flags = dpf;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, 64'(out_valid), 64'd1);
      check({req, " result"}, out_result, exp_r);
      check({req, " flags"}, 64'(out_flags), 64'(exp_f));
   endtask

   task automatic t_reset;
      check("R12 valid", 64'(out_valid), 64'd0);
      check("R12 result", out_result, 64'd0);
      check("R12 flags", 64'(out_flags), 64'd0);
   endtask

   task automatic t_priority;
      run(qn(1), ONE, ONE, 1'b0, SPILL, 4'b0111, "R1 lone addend", qn(1), 4'b0000);
      run(ONE, ONE, qn(2), 1'b0, SPILL, 4'b0111, "R2 lone mul_b", qn(2), 4'b0000);
      run(ONE, qn(3), ONE, 1'b0, SPILL, 4'b0111, "R2 lone mul_a", qn(3), 4'b0000);
      run(qn(1), qn(3), qn(2), 1'b0, SPILL, 4'b0000, "R1 all three", qn(1), 4'b0000);
      run(ONE, qn(3), qn(2), 1'b0, SPILL, 4'b0000, "R2 both mults", qn(2), 4'b0000);
      run(qn(1), qn(3), ONE, 1'b0, SPILL, 4'b0000, "R1 over mul_a", qn(1), 4'b0000);
      run(qn(1), ONE, qn(2), 1'b0, SPILL, 4'b0000, "R7 quiet pair", qn(1), 4'b0000);
   endtask

   task automatic t_quiet_and_invalid;
      run(ONE, ONE, 64'hFFF0_0000_0000_0005, 1'b0, SPILL, 4'b0111,
          "R3 quiet keeps sign payload", 64'hFFF8_0000_0000_0005, 4'b1000);
      run(sn(1), sn(3), sn(2), 1'b0, SPILL, 4'b0000, "R4 all signalling", qn(1), 4'b1000);
      run(qn(1), ONE, sn(2), 1'b0, SPILL, 4'b0111, "R4 unselected snan", qn(1), 4'b1000);
      run(ONE, sn(3), qn(2), 1'b0, SPILL, 4'b0000, "R4 snan mul_a loses", qn(2), 4'b1000);
   endtask

   task automatic t_inf_zero;
      run(ONE, PINF, ZERO, 1'b0, SPILL, 4'b0111, "R5 inf*0", DNAN, 4'b1000);
      run(TWO, NZRO, NINF, 1'b0, SPILL, 4'b0001, "R5 -0*-inf", DNAN, 4'b1000);
      run(qn(1), PINF, ZERO, 1'b0, SPILL, 4'b0000, "R6 qnan addend", qn(1), 4'b1000);
      run(sn(1), ZERO, PINF, 1'b0, SPILL, 4'b0000, "R6 snan addend", qn(1), 4'b1000);
   endtask

   task automatic t_subtract;
      run(qn(1), sn(3), qn(2), 1'b1, SPILL, 4'b0111, "R8 sub addend", qn(1), 4'b1000);
      run(ONE, qn(3), qn(2), 1'b1, SPILL, 4'b0000, "R8 sub mul_b", qn(2), 4'b0000);
      run(ONE, PINF, ZERO, 1'b1, SPILL, 4'b0000, "R8 sub inf*0", DNAN, 4'b1000);
   endtask

   task automatic t_passthru;
      run(ONE, ONE, ONE, 1'b0, TWO, 4'b0001, "R10 ordinary", TWO, 4'b0001);
      run(ONE, PINF, TWO, 1'b1, PINF, 4'b0000, "R10 inf times finite", PINF, 4'b0000);
      run(PINF, ZERO, ONE, 1'b0, PINF, 4'b0100, "R9 R10 no override keeps flags", PINF, 4'b0100);
   endtask

   task automatic t_hold;
      @(negedge clk);
      in_valid = 1'b0; addend = qn(9); mul_a = ONE; mul_b = ONE; dp_result = ONE; dp_flags = 4'b1111;
      @(negedge clk);
      @(negedge clk);
      check("R11 idle valid", 64'(out_valid), 64'd0);
      check("R11 hold result", out_result, PINF);
      check("R11 hold flags", 64'(out_flags), 64'(4'b0100));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_priority();
      t_quiet_and_invalid();
      t_inf_zero();
      t_subtract();
      t_passthru();
      t_hold();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule